// File: doc/BRIEF.md
# Line Latch with Polarity Reference-Bank Selector

This block sits between the input data register of a display column driver and its per-channel digital-to-analog converters. A line strobe (`line_stb`) is sampled in the block clock domain. On the strobe's rising edge, the block copies the whole filled data register into a line latch in a single step. It also sends a one-cycle clear to the sampling controller and holds capture off until the next start pulse arrives.

The latched codes are marked valid for the converters from the strobe's falling edge onward. Each channel also gets a reference-bank select. This select is derived from a polarity input, captured at the same rising edge, together with the channel's odd or even output number. Adjacent outputs therefore draw opposite-polarity gray-scale voltages, which supports dot inversion.

Channel count and code width are parameters.

Top module: `lls_line_latch`

## Requirements
- R1: After reset, `out_valid`, `cap_clear` and `cap_hold` are 0, every `chan_code` field is 0, and the captured polarity is low.
- R2: When the clock detects a rising edge of `line_stb`, channel k's field `chan_code[k*CW +: CW]` takes `line_data[k*CW +: CW]` from that edge.
- R3: `chan_code` keeps its value at every other clock edge, whatever `line_data` does, including while `line_stb` stays high.
- R4: `pol_in` is sampled only at the detected rising edge of `line_stb`. Changing it at any other time has no effect on `bank_hi`.
- R5: With captured polarity high, odd-numbered outputs use the upper bank (`bank_hi`=1) and even-numbered outputs use the lower bank (`bank_hi`=0). Output n is channel index n-1, so channel 0 is output 1, which is odd.
- R6: With captured polarity low, the bank assignment of R5 is swapped: odd-numbered outputs get `bank_hi`=0 and even-numbered outputs get `bank_hi`=1.
- R7: `out_valid` goes to 1 at the clock edge that detects a falling edge of `line_stb`, and to 0 at the edge that detects a rising edge.
- R8: `cap_clear` is 1 for exactly one cycle, starting at the edge that detects a rising edge of `line_stb`.
- R9: `cap_hold` becomes 1 at a detected rising edge of `line_stb`. It returns to 0 at the first later edge where `start_in` is 1. A rising strobe edge takes priority over a start pulse at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | Line strobe, edges detected in the `clk` domain |
| start_in | input | 1 | Start pulse that re-arms capture |
| pol_in | input | 1 | Polarity control |
| line_data | input | NCH*CW | Filled data register, channel k at bits k*CW +: CW |
| chan_code | output | NCH*CW | Latched per-channel codes for the converters |
| bank_hi | output | NCH | Per-channel bank select, 1 = upper bank (references 9 to 16) |
| out_valid | output | 1 | Latched line is being driven |
| cap_clear | output | 1 | One-cycle clear to the sampling controller |
| cap_hold | output | 1 | Capture blocked until the next start pulse |

## Verification
Each internal state register in this block reaches a port within one clock edge. A wrong strobe-history bit shows up as a missing or extra load of `chan_code`, and as `out_valid` or `cap_clear` out of step, at the very next edge after a strobe change. A polarity register that is captured at the wrong time shows up as a flipped `bank_hi` pattern in the first sample after `pol_in` is toggled mid-line. A stuck hold flag shows up as `cap_hold` failing to drop one edge after `start_in`.

// File: rtl/lls_pkg.sv
package lls_pkg;
   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } bank_e;

   function automatic bank_e pick_bank(input logic pol, input int unsigned idx);
      // index 0 is output 1 (odd)
      logic odd_out;
      odd_out = (idx % 2) == 0;
      return (pol ~^ odd_out) ? BANK_HI : BANK_LO;
   endfunction
endpackage

// File: rtl/lls_strobe_ctl.sv
module lls_strobe_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic line_stb,
   input  logic start_in,
   input  logic pol_in,
   output logic load_en,
   output logic pol_cap,
   output logic out_valid,
   output logic cap_clear,
   output logic cap_hold
);
   logic stb_q;
   logic fall;

   assign load_en = line_stb & ~stb_q;
   assign fall    = ~line_stb & stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q     <= 1'b0;
         pol_cap   <= 1'b0;
         out_valid <= 1'b0;
         cap_clear <= 1'b0;
         cap_hold  <= 1'b0;
      end else begin
         stb_q     <= line_stb;
         cap_clear <= load_en;
         if (load_en) begin
            pol_cap   <= pol_in;
            out_valid <= 1'b0;
            cap_hold  <= 1'b1;
         end else begin
            if (fall)     out_valid <= 1'b1;
            if (start_in) cap_hold  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lls_chan_latch.sv
module lls_chan_latch #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [CW-1:0] din,
   output logic [CW-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout <= '0;
      else if (load_en) dout <= din;
   end
endmodule

// File: rtl/lls_bank_map.sv
module lls_bank_map #(
   parameter int unsigned NCH = 6
) (
   input  logic           pol_cap,
   output logic [NCH-1:0] bank_hi
);
   import lls_pkg::*;

   for (genvar i = 0; i < NCH; i++) begin : g_map
      assign bank_hi[i] = (pick_bank(pol_cap, i) == BANK_HI);
   end
endmodule

// File: rtl/lls_line_latch.sv
module lls_line_latch #(
   parameter int unsigned NCH = 6,
   parameter int unsigned CW  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_stb,
   input  logic               start_in,
   input  logic               pol_in,
   input  logic [NCH*CW-1:0]  line_data,
   output logic [NCH*CW-1:0]  chan_code,
   output logic [NCH-1:0]     bank_hi,
   output logic               out_valid,
   output logic               cap_clear,
   output logic               cap_hold
);
   localparam int unsigned BUS_W = NCH * CW;

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (CW < 1 || CW > 16) begin : g_bad_cw
      $error("CW must be in 1..16");
   end

   logic load_en;
   logic pol_cap;

   lls_strobe_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_stb  (line_stb),
      .start_in  (start_in),
      .pol_in    (pol_in),
      .load_en   (load_en),
      .pol_cap   (pol_cap),
      .out_valid (out_valid),
      .cap_clear (cap_clear),
      .cap_hold  (cap_hold)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      lls_chan_latch #(.CW(CW)) u_lat (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_en (load_en),
         .din     (line_data[k*CW +: CW]),
         .dout    (chan_code[k*CW +: CW])
      );
   end

   lls_bank_map #(.NCH(NCH)) u_map (
      .pol_cap (pol_cap),
      .bank_hi (bank_hi)
   );

   logic [BUS_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: rtl/lls_line_latch_chk.sv
module lls_line_latch_chk #(
   parameter int unsigned NCH = 6,
   parameter int unsigned CW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_stb,
   input logic              start_in,
   input logic [NCH*CW-1:0] line_data,
   input logic [NCH*CW-1:0] chan_code,
   input logic [NCH-1:0]    bank_hi,
   input logic              out_valid,
   input logic              cap_clear,
   input logic              cap_hold
);
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_stb) |=> chan_code == $past(line_data));

   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(line_stb) |=> $stable(chan_code));

   assert_bank_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(line_stb) |=> $stable(bank_hi));

   assert_valid_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_stb) |=> out_valid);

   assert_valid_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_stb) |=> !out_valid);

   assert_clear_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clear |=> !cap_clear);

   assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_in && !$rose(line_stb)) |=> !cap_hold);

   if (NCH >= 2) begin : g_alt
      assert_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
         bank_hi[0] != bank_hi[1]);
   end
endmodule

bind lls_line_latch lls_line_latch_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_stb  (line_stb),
   .start_in  (start_in),
   .line_data (line_data),
   .chan_code (chan_code),
   .bank_hi   (bank_hi),
   .out_valid (out_valid),
   .cap_clear (cap_clear),
   .cap_hold  (cap_hold)
);

// File: tb/sim_lls_line_latch.sv
`timescale 1ns/1ps
module sim_lls_line_latch;
   localparam int NCH = 6;
   localparam int CW  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              line_stb = 1'b0;
   logic              start_in = 1'b0;
   logic              pol_in = 1'b0;
   logic [NCH*CW-1:0] line_data = '0;
   logic [NCH*CW-1:0] chan_code;
   logic [NCH-1:0]    bank_hi;
   logic              out_valid, cap_clear, cap_hold;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   lls_line_latch #(.NCH(NCH), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .start_in(start_in),
      .pol_in(pol_in), .line_data(line_data), .chan_code(chan_code),
      .bank_hi(bank_hi), .out_valid(out_valid), .cap_clear(cap_clear),
      .cap_hold(cap_hold)
   );

   localparam logic [NCH-1:0] ODD_HI  = 6'b010101;
   localparam logic [NCH-1:0] EVEN_HI = 6'b101010;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 valid", 64'(out_valid), 0);
      check("R1 codes", 64'(chan_code), 0);
      check("R1 clear", 64'(cap_clear), 0);
      check("R1 hold", 64'(cap_hold), 0);
      check("R1 bank", 64'(bank_hi), 64'(EVEN_HI));
   endtask

   task automatic t_latch();
      line_data = 48'h0102_0304_A5FF;
      pol_in = 1'b1;
      line_stb = 1'b1;
      tick();
      check("R2 codes", 64'(chan_code), 64'h0102_0304_A5FF);
      check("R7 valid low", 64'(out_valid), 0);
      check("R8 clear high", 64'(cap_clear), 1);
      check("R9 hold set", 64'(cap_hold), 1);
      check("R5 bank", 64'(bank_hi), 64'(ODD_HI));
      tick();
      check("R8 clear one cycle", 64'(cap_clear), 0);
      line_stb = 1'b0;
      tick();
      check("R7 valid high", 64'(out_valid), 1);
   endtask

   task automatic t_ignore();
      line_data = 48'hDEAD_BEEF_0000;
      tick(); tick(); tick();
      check("R3 steady low", 64'(chan_code), 64'h0102_0304_A5FF);
      line_data = 48'h1111_2222_3333;
      line_stb = 1'b1;
      tick();
      line_data = 48'h9999_8888_7777;
      tick(); tick();
      check("R3 steady high", 64'(chan_code), 64'h1111_2222_3333);
      line_stb = 1'b0;
      tick();
   endtask

   task automatic t_pol();
      pol_in = 1'b0;
      line_stb = 1'b1;
      tick();
      check("R6 bank", 64'(bank_hi), 64'(EVEN_HI));
      pol_in = 1'b1;
      tick(); tick();
      check("R4 pol mid line", 64'(bank_hi), 64'(EVEN_HI));
      line_stb = 1'b0;
      tick(); tick();
      check("R4 pol after fall", 64'(bank_hi), 64'(EVEN_HI));
      line_stb = 1'b1;
      pol_in = 1'b0;
      tick();
      check("R4 pol sampled low", 64'(bank_hi), 64'(EVEN_HI));
      line_stb = 1'b0;
      pol_in = 1'b1;
      tick();
      line_stb = 1'b1;
      tick();
      check("R5 bank again", 64'(bank_hi), 64'(ODD_HI));
      line_stb = 1'b0;
      tick();
   endtask

   task automatic t_hold();
      check("R9 hold before start", 64'(cap_hold), 1);
      start_in = 1'b1;
      tick();
      start_in = 1'b0;
      check("R9 hold released", 64'(cap_hold), 0);
      line_stb = 1'b1;
      start_in = 1'b1;
      tick();
      start_in = 1'b0;
      check("R9 strobe wins", 64'(cap_hold), 1);
      tick();
      check("R9 hold kept", 64'(cap_hold), 1);
      line_stb = 1'b0;
      tick();
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_latch();
      t_ignore();
      t_pol();
      t_hold();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule